// File: doc/BRIEF.md
# Guard-Bit Multiply-Accumulate Unit

This block is the arithmetic core of a 16-bit fixed-point signal processor. It holds four interchangeable 40-bit accumulators, each made of a 16-bit low word, a 16-bit high word and an 8-bit guard field. Each cycle it accepts at most one operation. The operation takes two 16-bit operands and widens each to 17 bits under a sign-extension mode. It forms their 17x17 signed product and then writes that product, adds it to the chosen accumulator, or subtracts it from that accumulator. A fourth operation loads one widened 16-bit operand. The result reaches the accumulator one clock edge after the operation is presented.

Overflow is judged either at the 32-bit boundary (guard bits treated as headroom) or at the full 40-bit width, depending on a mode input. A saturation mode clamps an overflowing result to the largest or smallest value of the active width. Without it, the 40-bit result keeps its two's-complement wrap. A per-operation overflow pulse and a sticky overflow flag per accumulator report overflow events. A separate word port reads and writes each accumulator part directly. A 16-bit temporary register can stand in for the second multiplicand.

Top module: `gmac_core`

## Requirements
- R1: After reset every accumulator, every sticky flag, the overflow pulse and the temporary register are zero.
- R2: An operation changes only the accumulator named by `accSel`, and the new value is visible after the next rising clock edge. Every other accumulator keeps its value.
- R3: With `signMode`=1 each operand is widened to 17 bits by copying bit 15. With `signMode`=0 it is widened by a zero bit. The product is the signed 17x17 product of the widened operands.
- R4: `opCode` values are 0 = multiply (accumulator := product), 1 = accumulate (accumulator + product), 2 = subtract (accumulator - product), 3 = load (accumulator := `opA` widened to 40 bits, with bit 15 copied upward when `signMode`=1 and zeros filled when it is 0).
- R5: With `useTmp`=1 the second multiplicand is the temporary register instead of `opB`. A write through `tmpWe`/`tmpData` takes effect for operations in later cycles.
- R6: With `wide40Mode`=0, a result outside the signed 32-bit range is an overflow. With `satMode`=1 it is clamped to 0x00_7FFF_FFFF or 0xFF_8000_0000. With `satMode`=0 the result is kept modulo 2^40.
- R7: With `wide40Mode`=1, a result outside the signed 40-bit range is an overflow. With `satMode`=1 it is clamped to 0x7F_FFFF_FFFF or 0x80_0000_0000. With `satMode`=0 it wraps modulo 2^40.
- R8: `opOvf` is high for the one cycle after an operation that overflowed. The sticky flag `ovfFlags[i]` is set by any overflow into accumulator i, whether or not saturation is on. It is cleared only by `ovfClr[i]`, and a set in the same cycle wins over a clear.
- R9: Word part codes are 0 = bits 15:0, 1 = bits 31:16, 2 = guard bits 39:32 (written from `wrData[7:0]`, read zero-extended), 3 = none (reads zero, writes ignored). `rdData` and `rdFull` follow `rdSel`/`rdPart` combinationally.
- R10: If a word write and an operation name the same accumulator in one cycle, only the operation takes effect. If they name different accumulators, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Issue an operation this cycle |
| opCode | input | 2 | Operation kind (see R4) |
| accSel | input | 2 | Target accumulator of the operation |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| useTmp | input | 1 | Take the second multiplicand from the temporary register |
| tmpWe | input | 1 | Write the temporary register |
| tmpData | input | 16 | Temporary register write data |
| signMode | input | 1 | Sign-extend operands when 1, zero-extend when 0 |
| satMode | input | 1 | Clamp overflowing results |
| wide40Mode | input | 1 | Judge overflow at 40 bits instead of 32 |
| wrEn | input | 1 | Word write enable |
| wrAcc | input | 2 | Accumulator of the word write |
| wrPart | input | 2 | Part of the word write (see R9) |
| wrData | input | 16 | Word write data |
| ovfClr | input | 4 | Per-accumulator sticky flag clear |
| rdSel | input | 2 | Accumulator for the read port |
| rdPart | input | 2 | Part for the read port (see R9) |
| rdData | output | 16 | Selected word of the selected accumulator |
| rdFull | output | 40 | Whole selected accumulator |
| ovfFlags | output | 4 | Sticky overflow flag per accumulator |
| opOvf | output | 1 | Overflow of the previous cycle's operation |

## Verification
A corrupted accumulator bit or a misrouted write is visible on `rdFull` at the first falling edge after the faulty edge. The bench compares all four accumulators there in every cycle, so the error shows with no delay and does not need a later operation to expose it. A wrong overflow decision shows up in the same cycle as a clamped or unclamped value, an `opOvf` mismatch and a flag mismatch. A flag that fails to stay set is caught in the first cycle it drops without a clear. The corner cases include multiplications of unsigned extremes and sums that cross the 32-bit and 40-bit limits in both directions, each with saturation on and off.

// File: rtl/gmac_pkg.sv
package gmac_pkg;
  localparam int OP_W       = 16;
  localparam int EXT_W      = OP_W + 1;
  localparam int PROD_W     = 2 * EXT_W;
  localparam int ACC_W      = 40;
  localparam int GUARD_W    = ACC_W - 2 * OP_W;
  localparam int NARROW_MSB = 2 * OP_W - 1;
  localparam int NACC       = 4;
  localparam int SEL_W      = $clog2(NACC);

  typedef enum logic [1:0] {
    OP_MPY  = 2'd0,
    OP_MAC  = 2'd1,
    OP_MSU  = 2'd2,
    OP_LOAD = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    PART_LO   = 2'd0,
    PART_HI   = 2'd1,
    PART_GD   = 2'd2,
    PART_NONE = 2'd3
  } part_e;

  typedef struct packed {
    logic             opGo;
    opKind_e          kind;
    logic [SEL_W-1:0] tgt;
    logic [NACC-1:0]  opHit;
    logic [NACC-1:0]  wordHit;
    part_e            part;
    logic [NACC-1:0]  clr;
  } strobe_t;
endpackage

// File: rtl/gmac_ctrl.sv
module gmac_ctrl
  import gmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic [SEL_W-1:0] accSel,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrAcc,
  input  logic [1:0]       wrPart,
  input  logic [NACC-1:0]  ovfClr,
  output strobe_t          st
);

  always_comb begin
    st      = '0;
    st.opGo = opValid;
    st.kind = opKind_e'(opCode);
    st.tgt  = accSel;
    st.part = part_e'(wrPart);
    st.clr  = ovfClr;
    for (int i = 0; i < NACC; i++) begin
      st.opHit[i]   = opValid && (accSel == SEL_W'(i));
      st.wordHit[i] = wrEn && (wrAcc == SEL_W'(i)) &&
                      (part_e'(wrPart) != PART_NONE) &&
                      !(opValid && (accSel == SEL_W'(i)));
    end
  end

  // R10: a word write that collides with an operation is dropped
  p_op_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && wrEn && (wrAcc == accSel)) |-> (st.wordHit == '0));

endmodule

// File: rtl/gmac_dp.sv
module gmac_dp
  import gmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          st,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  logic             useTmp,
  input  logic             tmpWe,
  input  logic [OP_W-1:0]  tmpData,
  input  logic             signMode,
  input  logic             satMode,
  input  logic             wide40Mode,
  input  logic [OP_W-1:0]  wrData,
  input  logic [SEL_W-1:0] rdSel,
  input  logic [1:0]       rdPart,
  output logic [OP_W-1:0]  rdData,
  output logic [ACC_W-1:0] rdFull,
  output logic [NACC-1:0]  ovfFlags,
  output logic             opOvf
);

  localparam logic [ACC_W-1:0] SAT_N_POS = {{(ACC_W-NARROW_MSB){1'b0}}, {NARROW_MSB{1'b1}}};
  localparam logic [ACC_W-1:0] SAT_N_NEG = {{(ACC_W-NARROW_MSB){1'b1}}, {NARROW_MSB{1'b0}}};
  localparam logic [ACC_W-1:0] SAT_W_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_W_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] accArr [NACC];
  logic [OP_W-1:0]  tmpQ;

  logic [OP_W-1:0]          bSrc;
  logic signed [EXT_W-1:0]  xA, xB;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W:0]    prodX, accX, loadX, sumX;
  logic [ACC_W-NARROW_MSB:0] topBits;
  logic                     ovfNarrow, ovfWide, ovfNow;
  logic [ACC_W-1:0]         result;

  // operand widening and 17x17 product
  always_comb begin
    bSrc  = useTmp ? tmpQ : opB;
    xA    = {signMode & opA[OP_W-1], opA};
    xB    = {signMode & bSrc[OP_W-1], bSrc};
    prod  = xA * xB;
    prodX = {{(ACC_W+1-PROD_W){prod[PROD_W-1]}}, prod};
    accX  = {accArr[st.tgt][ACC_W-1], accArr[st.tgt]};
    loadX = {{(ACC_W+1-OP_W){signMode & opA[OP_W-1]}}, opA};
  end

  // accumulate, overflow judgement and clamp
  always_comb begin
    case (st.kind)
      OP_MPY:  sumX = prodX;
      OP_MAC:  sumX = accX + prodX;
      OP_MSU:  sumX = accX - prodX;
      default: sumX = loadX;
    endcase
    topBits   = sumX[ACC_W:NARROW_MSB];
    ovfNarrow = !((&topBits) || (~|topBits));
    ovfWide   = sumX[ACC_W] ^ sumX[ACC_W-1];
    ovfNow    = wide40Mode ? ovfWide : ovfNarrow;
    if (ovfNow && satMode) begin
      if (wide40Mode) result = sumX[ACC_W] ? SAT_W_NEG : SAT_W_POS;
      else            result = sumX[ACC_W] ? SAT_N_NEG : SAT_N_POS;
    end else begin
      result = sumX[ACC_W-1:0];
    end
  end

  // storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmpQ     <= '0;
      opOvf    <= 1'b0;
      ovfFlags <= '0;
      for (int i = 0; i < NACC; i++) accArr[i] <= '0;
    end else begin
      if (tmpWe) tmpQ <= tmpData;
      opOvf <= st.opGo && ovfNow;
      for (int i = 0; i < NACC; i++) begin
        if (st.opHit[i]) begin
          accArr[i] <= result;
        end else if (st.wordHit[i]) begin
          case (st.part)
            PART_LO: accArr[i][OP_W-1:0]      <= wrData;
            PART_HI: accArr[i][2*OP_W-1:OP_W] <= wrData;
            PART_GD: accArr[i][ACC_W-1:2*OP_W] <= wrData[GUARD_W-1:0];
            default: ;
          endcase
        end
        if (st.opHit[i] && ovfNow) ovfFlags[i] <= 1'b1;
        else if (st.clr[i])        ovfFlags[i] <= 1'b0;
      end
    end
  end

  // read port
  always_comb begin
    rdFull = accArr[rdSel];
    case (part_e'(rdPart))
      PART_LO: rdData = rdFull[OP_W-1:0];
      PART_HI: rdData = rdFull[2*OP_W-1:OP_W];
      PART_GD: rdData = {{(OP_W-GUARD_W){1'b0}}, rdFull[ACC_W-1:2*OP_W]};
      default: rdData = '0;
    endcase
  end

  // R6: saturated narrow results stay inside the signed 32-bit range
  p_narrow_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st.opGo && satMode && !wide40Mode) |=>
      ((accArr[$past(st.tgt)][ACC_W-1:NARROW_MSB] == '0) ||
       (accArr[$past(st.tgt)][ACC_W-1:NARROW_MSB] == '1)));

  // R4: unsigned load leaves the upper bits clear
  p_load_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st.opGo && (st.kind == OP_LOAD) && !signMode) |=>
      (accArr[$past(st.tgt)][ACC_W-1:OP_W] == '0));

  // R8: an overflow pulse always comes with a raised flag
  p_pulse_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    opOvf |-> (ovfFlags != '0));

  for (genvar g = 0; g < NACC; g++) begin : g_chk
    // R2: untargeted accumulators hold
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!st.opHit[g] && !st.wordHit[g]) |=> $stable(accArr[g]));
    // R8: flags stay set until cleared
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovfFlags[g] && !st.clr[g]) |=> ovfFlags[g]);
  end

endmodule

// File: rtl/gmac_core.sv
module gmac_core
  import gmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        opValid,
  input  logic [1:0]  opCode,
  input  logic [1:0]  accSel,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic        useTmp,
  input  logic        tmpWe,
  input  logic [15:0] tmpData,
  input  logic        signMode,
  input  logic        satMode,
  input  logic        wide40Mode,
  input  logic        wrEn,
  input  logic [1:0]  wrAcc,
  input  logic [1:0]  wrPart,
  input  logic [15:0] wrData,
  input  logic [3:0]  ovfClr,
  input  logic [1:0]  rdSel,
  input  logic [1:0]  rdPart,
  output logic [15:0] rdData,
  output logic [39:0] rdFull,
  output logic [3:0]  ovfFlags,
  output logic        opOvf
);

  strobe_t st;

  gmac_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .accSel(accSel), .wrEn(wrEn), .wrAcc(wrAcc), .wrPart(wrPart),
    .ovfClr(ovfClr), .st(st)
  );

  gmac_dp u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .opA(opA), .opB(opB),
    .useTmp(useTmp), .tmpWe(tmpWe), .tmpData(tmpData),
    .signMode(signMode), .satMode(satMode), .wide40Mode(wide40Mode),
    .wrData(wrData), .rdSel(rdSel), .rdPart(rdPart), .rdData(rdData),
    .rdFull(rdFull), .ovfFlags(ovfFlags), .opOvf(opOvf)
  );

endmodule

// File: tb/gmac_core_bench.sv
module gmac_core_bench;
  localparam int CLK_P = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic opValid = 0, useTmp = 0, tmpWe = 0, signMode = 0, satMode = 0, wide40Mode = 0, wrEn = 0;
  logic [1:0] opCode = 0, accSel = 0, wrAcc = 0, wrPart = 0, rdSel = 0, rdPart = 0;
  logic [15:0] opA = 0, opB = 0, tmpData = 0, wrData = 0;
  logic [3:0] ovfClr = 0;
  logic [15:0] rdData;
  logic [39:0] rdFull;
  logic [3:0] ovfFlags;
  logic opOvf;

  int total = 0, bad = 0;
  string curTag = "R1";
  bit finished = 0;

  longint accM [4];
  bit     flagM [4];
  bit     pulseM;
  logic [15:0] tmpM;

  always #(CLK_P/2) clk = ~clk;

  gmac_core u_gmac_core (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode), .accSel(accSel),
    .opA(opA), .opB(opB), .useTmp(useTmp), .tmpWe(tmpWe), .tmpData(tmpData),
    .signMode(signMode), .satMode(satMode), .wide40Mode(wide40Mode),
    .wrEn(wrEn), .wrAcc(wrAcc), .wrPart(wrPart), .wrData(wrData), .ovfClr(ovfClr),
    .rdSel(rdSel), .rdPart(rdPart), .rdData(rdData), .rdFull(rdFull),
    .ovfFlags(ovfFlags), .opOvf(opOvf)
  );

  function automatic longint wrap40(longint v);
    longint m;
    m = v & ((64'sd1 <<< 40) - 1);
    if (m[39]) m = m - (64'sd1 <<< 40);
    return m;
  endfunction

  task automatic chk(input string what, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", curTag, what, act, exp);
    end
  endtask

  // reference model step, applied with the inputs currently driven
  task automatic modelStep();
    longint ea, eb, p, s, hi, lo, r;
    logic [15:0] b;
    logic [39:0] w;
    bit ov;
    ov = 0;
    if (opValid) begin
      b  = useTmp ? tmpM : opB;
      ea = signMode ? longint'(shortint'(opA)) : longint'({16'd0, opA});
      eb = signMode ? longint'(shortint'(b))   : longint'({16'd0, b});
      p  = ea * eb;
      case (opCode)
        2'd0: s = p;
        2'd1: s = accM[accSel] + p;
        2'd2: s = accM[accSel] - p;
        default: s = ea;
      endcase
      if (wide40Mode) begin hi = (64'sd1 <<< 39) - 1; lo = -(64'sd1 <<< 39); end
      else            begin hi = (64'sd1 <<< 31) - 1; lo = -(64'sd1 <<< 31); end
      ov = (s > hi) || (s < lo);
      if (ov && satMode) r = (s > hi) ? hi : lo;
      else               r = wrap40(s);
      accM[accSel] = r;
    end
    if (wrEn && wrPart != 2'd3 && !(opValid && wrAcc == accSel)) begin
      w = accM[wrAcc][39:0];
      case (wrPart)
        2'd0: w[15:0]  = wrData;
        2'd1: w[31:16] = wrData;
        default: w[39:32] = wrData[7:0];
      endcase
      accM[wrAcc] = wrap40(longint'({24'd0, w}));
    end
    for (int i = 0; i < 4; i++) begin
      if (opValid && accSel == 2'(i) && ov) flagM[i] = 1;
      else if (ovfClr[i]) flagM[i] = 0;
    end
    pulseM = opValid && ov;
    if (tmpWe) tmpM = tmpData;
  endtask

  task automatic compareAll();
    logic [39:0] e;
    for (int i = 0; i < 4; i++) begin
      e = accM[i][39:0];
      for (int pt = 0; pt < 4; pt++) begin
        rdSel = 2'(i); rdPart = 2'(pt);
        #1;
        if (pt == 0) chk($sformatf("acc%0d full", i), rdFull, e);
        case (pt)
          0: chk($sformatf("acc%0d lo", i), {24'd0, rdData}, {24'd0, e[15:0]});
          1: chk($sformatf("acc%0d hi", i), {24'd0, rdData}, {24'd0, e[31:16]});
          2: chk($sformatf("acc%0d guard", i), {24'd0, rdData}, {32'd0, e[39:32]});
          default: chk($sformatf("acc%0d none", i), {24'd0, rdData}, 40'd0);
        endcase
      end
      chk($sformatf("flag%0d", i), {39'd0, ovfFlags[i]}, {39'd0, flagM[i]});
    end
    chk("opOvf", {39'd0, opOvf}, {39'd0, pulseM});
  endtask

  // one cycle: model, edge, compare at falling edge, drop pulses
  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    opValid = 0; wrEn = 0; tmpWe = 0; ovfClr = 0; useTmp = 0;
  endtask

  task automatic doOp(input logic [1:0] k, input logic [1:0] sel, input logic [15:0] a, input logic [15:0] b);
    opValid = 1; opCode = k; accSel = sel; opA = a; opB = b;
    tick();
  endtask

  task automatic doWr(input logic [1:0] sel, input logic [1:0] pt, input logic [15:0] d);
    wrEn = 1; wrAcc = sel; wrPart = pt; wrData = d;
    tick();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin accM[i] = 0; flagM[i] = 0; end
    pulseM = 0; tmpM = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    curTag = "R1";
    compareAll();

    // R4: load with sign fill and zero fill
    curTag = "R4";
    signMode = 1; doOp(2'd3, 2'd0, 16'h8001, 0);
    signMode = 0; doOp(2'd3, 2'd1, 16'h8001, 0);

    // R3: signed and unsigned widening
    curTag = "R3";
    signMode = 1; doOp(2'd0, 2'd2, 16'hFFFD, 16'd5);
    signMode = 0; wide40Mode = 1; doOp(2'd0, 2'd3, 16'hFFFF, 16'd2);
    signMode = 1; doOp(2'd0, 2'd3, 16'h8000, 16'h8000);

    // R4: accumulate and subtract chains
    curTag = "R4";
    doOp(2'd1, 2'd2, 16'd100, 16'd3);
    doOp(2'd2, 2'd2, 16'hFFFF, 16'd7);
    doOp(2'd2, 2'd1, 16'd2, 16'd2);

    // R5: temporary register multiplicand
    curTag = "R5";
    tmpWe = 1; tmpData = 16'd7; useTmp = 1; doOp(2'd0, 2'd0, 16'd6, 16'd1000);
    useTmp = 1; doOp(2'd0, 2'd0, 16'd6, 16'd1000);

    // R6: narrow overflow, wrap then clamp
    curTag = "R6";
    wide40Mode = 0; signMode = 0; satMode = 0;
    doOp(2'd0, 2'd0, 16'hFFFF, 16'hFFFF);
    satMode = 1; doOp(2'd0, 2'd1, 16'hFFFF, 16'hFFFF);
    doWr(2'd2, 2'd0, 16'h0000); doWr(2'd2, 2'd1, 16'h8000); doWr(2'd2, 2'd2, 16'h00FF);
    signMode = 1; doOp(2'd2, 2'd2, 16'd1, 16'd1);
    satMode = 0; doOp(2'd0, 2'd3, 16'h8000, 16'h8000);
    doOp(2'd1, 2'd3, 16'h8000, 16'h8000);

    // R7: wide overflow at the 40-bit limit
    curTag = "R7";
    wide40Mode = 1; satMode = 0;
    doWr(2'd1, 2'd0, 16'hFFFF); doWr(2'd1, 2'd1, 16'hFFFF); doWr(2'd1, 2'd2, 16'h007F);
    doOp(2'd1, 2'd1, 16'd1, 16'd1);
    doWr(2'd0, 2'd0, 16'hFFFF); doWr(2'd0, 2'd1, 16'hFFFF); doWr(2'd0, 2'd2, 16'h007F);
    satMode = 1; doOp(2'd1, 2'd0, 16'd1, 16'd1);
    doOp(2'd2, 2'd1, 16'd1, 16'd1);

    // R8: clear, and set winning over clear
    curTag = "R8";
    ovfClr = 4'b0011; tick();
    ovfClr = 4'b0100; satMode = 0; wide40Mode = 0; signMode = 0;
    doOp(2'd0, 2'd2, 16'hFFFF, 16'hFFFF);
    tick();

    // R9: part writes, part code 3 ignored
    curTag = "R9";
    doWr(2'd3, 2'd0, 16'h1234); doWr(2'd3, 2'd1, 16'hABCD); doWr(2'd3, 2'd2, 16'hFF5A);
    doWr(2'd3, 2'd3, 16'hFFFF);

    // R10: collision and parallel access
    curTag = "R10";
    signMode = 1; wide40Mode = 1;
    wrEn = 1; wrAcc = 2'd0; wrPart = 2'd1; wrData = 16'h5555; doOp(2'd3, 2'd0, 16'd9, 0);
    wrEn = 1; wrAcc = 2'd1; wrPart = 2'd0; wrData = 16'h6666; doOp(2'd3, 2'd0, 16'd10, 0);

    // R2: mixed random traffic, every accumulator compared each cycle
    curTag = "R2";
    for (int n = 0; n < 400; n++) begin
      signMode = 1'($urandom); satMode = 1'($urandom); wide40Mode = 1'($urandom);
      useTmp = ($urandom % 4) == 0;
      tmpWe = ($urandom % 5) == 0; tmpData = 16'($urandom);
      wrEn = ($urandom % 6) == 0; wrAcc = 2'($urandom); wrPart = 2'($urandom); wrData = 16'($urandom);
      ovfClr = ($urandom % 8) == 0 ? 4'($urandom) : 4'd0;
      opValid = ($urandom % 5) != 0;
      opCode = 2'($urandom); accSel = 2'($urandom);
      opA = ($urandom % 6) == 0 ? 16'h8000 : 16'($urandom);
      opB = ($urandom % 6) == 0 ? 16'hFFFF : 16'($urandom);
      tick();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule